// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns the address of a processor with a multiplexed address/data bus into active-low chip selects for a group of peripherals. Software programs a base address. Above that base lies a window of seven consecutive 256-byte regions. Each region except index 4 drives its own select line. The window can be placed in memory space or in I/O space, and only bus cycles of the matching type produce a select.

The decoder samples the address while the address-phase strobe is high. The select appears on the cycle right after that sample, while the address is still on the bus, and stays asserted until the bus cycle ends. Reset and bus hold force every select high. Two outputs are shared. In extended mode they are the selects for regions 5 and 6. Otherwise they carry address bits 1 and 2 as latched in the most recent address phase, and those latched bits keep their value through a bus hold.

Top module: `pcs_decoder`

## Requirements
- R1: With `ahi = addr_i[ADDR_W-1:8]` and `off = ahi - base_i` (only when `ahi >= base_i`), an address phase with `off` in 0..6 selects region `off`. At most one select is low at any time.
- R2: A select is produced only when `io_cycle_i` equals `space_io_i` (1 = I/O space, 0 = memory space). A mismatched address phase leaves every select high.
- R3: A select goes low on the first clock edge at which `ale_i` is 1 with a matching address, so it is visible in the following cycle. It stays low until the edge at which `cyc_done_i` is 1.
- R4: While `rst_n` is low at a clock edge, every select output is high and both latched address bits are cleared to 0.
- R5: A clock edge with `hold_i` = 1 drives every select high in the following cycle. Hold takes priority over a simultaneous address phase.
- R6: Offset 4, offsets of 7 or more, and addresses below the base assert no select.
- R7: With `ext_i` = 1, `pcs5_a1_o` and `pcs6_a2_o` are the active-low selects for regions 5 and 6.
- R8: With `ext_i` = 0, `pcs5_a1_o` carries address bit 1 and `pcs6_a2_o` carries address bit 2, as latched at the last address phase that was not under hold.
- R9: The latched address bits do not change during bus hold or outside address phases.
- R10: When `ale_i` and `cyc_done_i` are both 1 at the same edge, the new address phase wins and its decode is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Address from the multiplexed bus |
| io_cycle_i | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| ale_i | input | 1 | Address-phase strobe |
| cyc_done_i | input | 1 | End of current bus cycle |
| hold_i | input | 1 | Bus hold in effect |
| base_i | input | ADDR_W-8 | Base of the window in 256-byte units |
| space_io_i | input | 1 | Window space: 1 = I/O, 0 = memory |
| ext_i | input | 1 | 1 = shared outputs are selects, 0 = latched address bits |
| pcs_n_o | output | 4 | Active-low selects for regions 0 to 3 |
| pcs5_a1_o | output | 1 | Region 5 select or latched address bit 1 |
| pcs6_a2_o | output | 1 | Region 6 select or latched address bit 2 |

## Verification
The bench builds the decoder with its default 20-bit address, which gives a 12-bit base. This makes it cheap to place the base near zero and near the top of the address range. Random bases and addresses just below, inside and just beyond the seven-region window reach every region, the missing region 4, the below-base borrow and the over-range offsets. Both space settings and both modes of the shared pins are covered. Directed sequences cover hold during an address phase, address phase and cycle end on the same edge, and the retention of the latched bits.

// File: rtl/pcs_pkg.sv
// Package: constants shared by the peripheral chip select decoder.
// Assumes regions are 256 bytes and the window holds seven of them.
package pcs_pkg;
    localparam int PCS_REGION_SHIFT = 8;
    localparam int PCS_NUM_REGIONS  = 7;
    localparam int PCS_SKIP_IDX     = 4;
    localparam int PCS_IDX_W        = $clog2(PCS_NUM_REGIONS);
    localparam int PCS_LAT_LSB      = 1;
    localparam int PCS_LAT_W        = 2;
endpackage

// File: rtl/pcs_region_match.sv
// Module: pcs_region_match
// Purpose: combinational window decode. It subtracts the base from the upper
//   address bits and returns a one-hot vector of regions that are hit.
// Assumes: base is given in region units; the region at SKIP_IDX has no output.
module pcs_region_match
    import pcs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int SHIFT       = PCS_REGION_SHIFT,
    parameter int NUM_REGIONS = PCS_NUM_REGIONS,
    parameter int SKIP_IDX    = PCS_SKIP_IDX
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [ADDR_W-SHIFT-1:0] base_i,
    output logic [NUM_REGIONS-1:0]  hit_o
);
    localparam int HI_W  = ADDR_W - SHIFT;
    localparam int IDX_W = $clog2(NUM_REGIONS);

    logic [HI_W:0]      diff;
    logic               in_window;
    logic [IDX_W-1:0]   idx;

    // Purpose: offset from the base, with a borrow bit that flags addresses below the base.
    always_comb begin
        diff      = {1'b0, addr_i[ADDR_W-1:SHIFT]} - {1'b0, base_i};
        in_window = !diff[HI_W] && (diff[HI_W-1:0] < HI_W'(NUM_REGIONS));
        idx       = diff[IDX_W-1:0];
    end

    // One hit line per region; the skipped index is tied low.
    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_hit
        if (k == SKIP_IDX) begin : g_skip
            assign hit_o[k] = 1'b0;
        end else begin : g_live
            assign hit_o[k] = in_window && (idx == IDX_W'(k));
        end
    end
endmodule

// File: rtl/pcs_sel_reg.sv
// Module: pcs_sel_reg
// Purpose: holds the active region selects for the current bus cycle.
//   The decode is loaded at the address phase and cleared at cycle end,
//   on bus hold and on reset.
// Assumes: hit_i is one-hot or zero; the strobe and the cycle end are synchronous to clk.
module pcs_sel_reg #(
    parameter int NUM_REGIONS = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REGIONS-1:0] hit_i,
    input  logic                   ale_i,
    input  logic                   cyc_done_i,
    input  logic                   hold_i,
    input  logic                   io_cycle_i,
    input  logic                   space_io_i,
    output logic [NUM_REGIONS-1:0] sel_o
);
    logic                   space_ok;
    logic [NUM_REGIONS-1:0] sel_q;

    // Purpose: the cycle type must match the configured space.
    always_comb space_ok = (io_cycle_i == space_io_i);

    // Purpose: load, hold or clear the select set. Priority is reset, then hold, then address phase, then cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (hold_i) begin
            sel_q <= '0;
        end else if (ale_i) begin
            sel_q <= space_ok ? hit_i : '0;
        end else if (cyc_done_i) begin
            sel_q <= '0;
        end
    end

    assign sel_o = sel_q;

    // R2: a cycle of the wrong type never selects anything
    p_space_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && (io_cycle_i != space_io_i)) |=> (sel_q == '0));

    // R3: a cycle end with no new address phase releases the selects
    p_done_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done_i && !ale_i) |=> (sel_q == '0));

    // R3: between address phases with no cycle end or hold the selects are stable
    p_sel_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && !cyc_done_i && !hold_i) |=> $stable(sel_q));

    // R10: an address phase loads the decode even when it meets a cycle end
    p_ale_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_i && cyc_done_i && !hold_i && space_ok) |=> (sel_q == $past(hit_i)));
endmodule

// File: rtl/pcs_addr_hold.sv
// Module: pcs_addr_hold
// Purpose: keeps a slice of the address as captured at the last address phase.
// Assumes: the address is valid on the bus while the strobe is high.
module pcs_addr_hold #(
    parameter int ADDR_W = 20,
    parameter int LSB    = 1,
    parameter int WIDTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ale_i,
    input  logic              hold_i,
    output logic [WIDTH-1:0]  lat_o
);
    logic [WIDTH-1:0] lat_q;

    // Purpose: capture the slice in an address phase; keep it during hold and outside address phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (ale_i && !hold_i) begin
            lat_q <= addr_i[LSB +: WIDTH];
        end
    end

    assign lat_o = lat_q;

    // R9: bus hold freezes the latched bits
    p_hold_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(lat_q));

    // R9: without an address phase the latched bits do not move
    p_idle_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_i |=> $stable(lat_q));
endmodule

// File: rtl/pcs_decoder.sv
// Module: pcs_decoder (top)
// Purpose: active-low peripheral chip selects for a window of 256-byte regions
//   above a programmable base. Two pins are shared with latched address bits.
// Assumes: the configuration inputs (base, space, extended mode) change only while no cycle is in progress.
module pcs_decoder
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic                             io_cycle_i,
    input  logic                             ale_i,
    input  logic                             cyc_done_i,
    input  logic                             hold_i,
    input  logic [ADDR_W-PCS_REGION_SHIFT-1:0] base_i,
    input  logic                             space_io_i,
    input  logic                             ext_i,
    output logic [3:0]                       pcs_n_o,
    output logic                             pcs5_a1_o,
    output logic                             pcs6_a2_o
);
    localparam int NR = PCS_NUM_REGIONS;

    logic [NR-1:0]        hit;
    logic [NR-1:0]        sel;
    logic [PCS_LAT_W-1:0] lat;

    pcs_region_match #(
        .ADDR_W      (ADDR_W),
        .SHIFT       (PCS_REGION_SHIFT),
        .NUM_REGIONS (NR),
        .SKIP_IDX    (PCS_SKIP_IDX)
    ) u_match (
        .addr_i (addr_i),
        .base_i (base_i),
        .hit_o  (hit)
    );

    pcs_sel_reg #(
        .NUM_REGIONS (NR)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .ale_i      (ale_i),
        .cyc_done_i (cyc_done_i),
        .hold_i     (hold_i),
        .io_cycle_i (io_cycle_i),
        .space_io_i (space_io_i),
        .sel_o      (sel)
    );

    pcs_addr_hold #(
        .ADDR_W (ADDR_W),
        .LSB    (PCS_LAT_LSB),
        .WIDTH  (PCS_LAT_W)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .ale_i  (ale_i),
        .hold_i (hold_i),
        .lat_o  (lat)
    );

    // Dedicated selects for the low regions.
    for (genvar k = 0; k < 4; k++) begin : g_low
        assign pcs_n_o[k] = ~sel[k];
    end

    // Purpose: shared pins carry the region 5/6 selects or the latched address bits.
    always_comb begin
        pcs5_a1_o = ext_i ? ~sel[5] : lat[0];
        pcs6_a2_o = ext_i ? ~sel[6] : lat[1];
    end

    // R5: one hold edge later every dedicated select is high
    p_hold_all_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ((pcs_n_o == 4'hF) && (!ext_i || (pcs5_a1_o && pcs6_a2_o))));

    // R1: never more than one dedicated select low at once
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n_o));

    // R7: in extended mode at most one select of all six is low
    p_ext_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_i |-> $onehot0({~pcs_n_o, ~pcs5_a1_o, ~pcs6_a2_o}));
endmodule

// File: tb/pcs_decoder_tb.sv
module pcs_decoder_tb;
    localparam int AW = 20;
    localparam int BW = AW - 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          io_cyc, ale, done, hold, space_io, ext;
    logic [BW-1:0] base;
    logic [3:0]    pcs_n;
    logic          o5, o6;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    int   m_region;        // -1 = nothing selected
    logic [1:0] m_lat;

    always #5 clk = ~clk;

    pcs_decoder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .io_cycle_i(io_cyc),
        .ale_i(ale), .cyc_done_i(done), .hold_i(hold), .base_i(base),
        .space_io_i(space_io), .ext_i(ext), .pcs_n_o(pcs_n),
        .pcs5_a1_o(o5), .pcs6_a2_o(o6)
    );

    // Region index per R1/R6; -1 when no select belongs to the address.
    function automatic int region_of(logic [AW-1:0] a, logic [BW-1:0] b);
        int hi = int'(a >> 8);
        int off = hi - int'(b);
        if (off < 0 || off > 6 || off == 4) return -1;
        return off;
    endfunction

    function automatic logic [5:0] expect_pins(int reg_idx, logic [1:0] lat, logic e);
        logic [5:0] p;
        for (int k = 0; k < 4; k++) p[k] = (reg_idx != k);
        p[4] = e ? (reg_idx != 5) : lat[0];
        p[5] = e ? (reg_idx != 6) : lat[1];
        return p;
    endfunction

    task automatic check(string req);
        logic [5:0] act = {o6, o5, pcs_n};
        logic [5:0] exp = expect_pins(m_region, m_lat, ext);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pins actual=%b expected=%b (addr=%h base=%h)", req, act, exp, addr, base);
        end
    endtask

    // One clock: drive, update model at the edge (R2 R3 R5 R10 R4 R9), check after.
    task automatic step(string req);
        @(posedge clk);
        if (!rst_n) begin
            m_region = -1; m_lat = 2'b00;
        end else if (hold) begin
            m_region = -1;
        end else if (ale) begin
            m_region = (io_cyc == space_io) ? region_of(addr, base) : -1;
            m_lat = addr[2:1];
        end else if (done) begin
            m_region = -1;
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic idle();
        ale = 0; done = 0; hold = 0;
    endtask

    task automatic phase(logic [AW-1:0] a, logic io, string req);
        addr = a; io_cyc = io; ale = 1; done = 0; hold = 0;
        step(req);
        ale = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_region = -1; m_lat = 0;
        rst_n = 0; addr = '0; io_cyc = 0; idle(); base = 12'h040; space_io = 0; ext = 1;
        @(negedge clk);
        addr = 20'h04506; ale = 1;
        step("R4"); step("R4");
        rst_n = 1; idle();
        step("R4");

        // R1 R7: each region in memory space, extended mode
        for (int k = 0; k < 7; k++) begin
            phase({base + BW'(k), 8'h3C}, 1'b0, (k == 4) ? "R6" : (k >= 5 ? "R7" : "R1"));
            step("R3");                    // held without cycle end
            done = 1; step("R3"); done = 0;
        end
        // R6: just below base, just past window
        phase({base - 12'd1, 8'hFF}, 1'b0, "R6"); done = 1; step("R6"); done = 0;
        phase({base + 12'd7, 8'h00}, 1'b0, "R6"); done = 1; step("R6"); done = 0;
        // R2: wrong cycle type
        phase({base + 12'd2, 8'h10}, 1'b1, "R2"); done = 1; step("R2"); done = 0;
        space_io = 1;
        phase({base + 12'd2, 8'h10}, 1'b1, "R2"); done = 1; step("R2"); done = 0;
        space_io = 0;
        // R5: hold over a live select and over an address phase
        phase({base + 12'd1, 8'h00}, 1'b0, "R1");
        hold = 1; step("R5");
        addr = {base + 12'd3, 8'h06}; ale = 1; step("R5"); ale = 0; hold = 0; step("R9");
        // R10: address phase together with cycle end
        phase({base, 8'h00}, 1'b0, "R1");
        addr = {base + 12'd6, 8'h00}; ale = 1; done = 1; step("R10"); idle();
        done = 1; step("R3"); done = 0;
        // R8 R9: latched bits mode
        ext = 0;
        phase({base + 12'd5, 8'h02}, 1'b0, "R8");
        hold = 1; addr = 20'h00004; step("R9"); hold = 0;
        step("R9");
        phase({base + 12'd6, 8'h04}, 1'b0, "R8"); done = 1; step("R8"); done = 0;
        // base at extremes
        base = 12'h000; phase(20'h00200, 1'b0, "R1"); done = 1; step("R3"); done = 0;
        base = 12'hFFC; phase(20'hFFF80, 1'b0, "R1"); done = 1; step("R3"); done = 0;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                base = BW'($urandom); space_io = $urandom % 2; ext = $urandom % 2;
            end
            addr   = {base + BW'(($urandom % 10)) - BW'(1), 8'($urandom)};
            io_cyc = ($urandom % 4) != 0 ? space_io : ~space_io;
            ale    = ($urandom % 3) == 0;
            done   = ($urandom % 3) == 0;
            hold   = ($urandom % 12) == 0;
            step("R1 random");
        end
        idle(); step("R3");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule